// File: doc/BRIEF.md
# JTAG Debug Interrupt Request Register

This block gives a debug host a way to interrupt the CPU through the test access port. A standard 16-state TAP controller, clocked by TCK, drives an 8-bit instruction register. When the host shifts the interrupt instruction code into the instruction register and passes through the update state, a sticky request flag is set. While the flag is 1, a level interrupt line to the CPU stays high.

The flag lives in the CPU clock domain. CPU software reads it through a 16-bit read port and can clear it by writing 0 to bit 0, but it can never set it. When the interrupt instruction is the current instruction, a 32-bit data register sits on the scan path. Capture loads the zero-extended register image into it, and it shifts out LSB first. Data shifted in is dropped at update, so the scan side can only observe the flag. Every other instruction selects a 1-bit bypass stage.

The TCK-side set event is a toggle. It reaches the CPU domain through a two-flop synchronizer followed by an edge detector. The Test-Logic-Reset condition is synchronized the same way and clears the flag.

Top module: `dbgirq_top`

## Requirements
- R1: `cpu_rdata` bit 0 is the request flag and bits 15 to 1 always read 0; after system and TAP reset the whole word is 0.
- R2: Shifting 8'h60 into the instruction register (LSB first) and passing Update-IR sets the flag on the third `clk` rising edge after the TCK rising edge that leaves Update-IR; any other shifted value leaves the flag unchanged.
- R3: A CPU write (`cpu_wr_en` high at a `clk` rising edge) with `cpu_wdata[0]`=0 clears the flag; with `cpu_wdata[0]`=1 the flag keeps its value; bits 15 to 1 of the write have no effect.
- R4: `cpu_irq` is high exactly while the flag is 1 and stays high until the flag is cleared.
- R5: The flag is cleared when the TAP reaches Test-Logic-Reset (five TCK cycles with TMS=1, or `trst_n` low) and while `rst_n` is low; in Test-Logic-Reset the instruction register loads 8'hFF. No set occurs when reset is released.
- R6: With 8'h60 as the current instruction, the data path is 32 bits long, Capture-DR loads {16'h0, register}, and bits leave on TDO LSB first, so the first bit out is the flag.
- R7: With any other current instruction, the data path is one stage: Capture-DR loads 0, and each TDI bit appears on TDO one shift later.
- R8: Update-DR never changes the flag, whatever data was shifted in.
- R9: Capture-IR loads 8'h01, which shifts out on TDO LSB first during Shift-IR.
- R10: TDO changes only on the falling edge of TCK, and `tdo_oe` is high only in Shift-IR and Shift-DR.
- R11: If a set event and a CPU clear act on the same `clk` edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tms | input | 1 | Test mode select, sampled on TCK rising edge |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, updated on TCK falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high in shift states |
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cpu_wr_en | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | 16 | CPU write data; only bit 0 acts |
| cpu_rdata | output | 16 | Register read value |
| cpu_irq | output | 1 | Level interrupt request to the CPU |

## Verification
The set event arriving from the scan side and a CPU write of 0 can land on the same `clk` edge. The bench raises TCK for the Update-IR exit on a `clk` falling edge. Counting the two synchronizer stages and the edge detector places the set on the third `clk` rising edge, so the bench pulses a one-cycle clear write exactly on that edge. It first checks that the flag is still 0 one edge earlier. It then checks that the flag reads 1 after the collision edge and is still 1 later, which shows that the set won and the clear was not just delayed.

// File: rtl/dbgirq_pkg.sv
`timescale 1ns/1ps
package dbgirq_pkg;

  typedef enum logic [3:0] {
    TAP_RESET,
    TAP_IDLE,
    TAP_SEL_DR,
    TAP_CAP_DR,
    TAP_SHF_DR,
    TAP_EX1_DR,
    TAP_PAU_DR,
    TAP_EX2_DR,
    TAP_UPD_DR,
    TAP_SEL_IR,
    TAP_CAP_IR,
    TAP_SHF_IR,
    TAP_EX1_IR,
    TAP_PAU_IR,
    TAP_EX2_IR,
    TAP_UPD_IR
  } tap_state_e;

endpackage

// File: rtl/dbgirq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with a selectable reset value.
module dbgirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= chain_d;
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dbgirq_tap_fsm.sv
`timescale 1ns/1ps
// Sixteen-state test access port controller.
module dbgirq_tap_fsm
  import dbgirq_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      TAP_RESET:  state_d = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: state_d = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: state_d = tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_SHF_DR: state_d = tms ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_EX1_DR: state_d = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: state_d = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: state_d = tms ? TAP_UPD_DR : TAP_SHF_DR;
      TAP_UPD_DR: state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: state_d = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: state_d = tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_SHF_IR: state_d = tms ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_EX1_IR: state_d = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: state_d = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: state_d = tms ? TAP_UPD_IR : TAP_SHF_IR;
      TAP_UPD_IR: state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    state_d = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= TAP_RESET;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/dbgirq_scan_path.sv
`timescale 1ns/1ps
// Instruction register, data registers and TDO driver in the TCK domain.
module dbgirq_scan_path
  import dbgirq_pkg::*;
#(
  parameter int             IR_W        = 8,
  parameter logic [IR_W-1:0] IRQ_CMD     = 8'h60,
  parameter logic [IR_W-1:0] BYPASS_CODE = {IR_W{1'b1}},
  parameter logic [IR_W-1:0] IR_CAPT     = 8'h01,
  parameter int             DR_W        = 32,
  parameter int             REG_W       = 16
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic            flag_tck,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [IR_W-1:0] ir_q,
  output logic            set_tgl,
  output logic            tlr_q
);

  localparam int PAD_W = DR_W - REG_W;

  logic [IR_W-1:0]  ir_sr, ir_sr_d, ir_d;
  logic [DR_W-1:0]  dr_sr, dr_d;
  logic             byp, byp_d;
  logic             tgl_d;
  logic             sel_irq;
  logic [REG_W-1:0] reg_img;
  logic             tdo_d, oe_d;

  assign sel_irq = (ir_q == IRQ_CMD);
  assign reg_img = {{(REG_W-1){1'b0}}, flag_tck};

  always_comb begin
    ir_sr_d = ir_sr;
    ir_d    = ir_q;
    dr_d    = dr_sr;
    byp_d   = byp;
    tgl_d   = set_tgl;
    unique case (state)
      TAP_RESET:  ir_d = BYPASS_CODE;
      TAP_CAP_IR: ir_sr_d = IR_CAPT;
      TAP_SHF_IR: ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
      TAP_UPD_IR: begin
        ir_d = ir_sr;
        if (ir_sr == IRQ_CMD) begin
          tgl_d = ~set_tgl;
        end
      end
      TAP_CAP_DR: begin
        if (sel_irq) begin
          dr_d = {{PAD_W{1'b0}}, reg_img};
        end else begin
          byp_d = 1'b0;
        end
      end
      TAP_SHF_DR: begin
        if (sel_irq) begin
          dr_d = {tdi, dr_sr[DR_W-1:1]};
        end else begin
          byp_d = tdi;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr   <= '0;
      ir_q    <= BYPASS_CODE;
      dr_sr   <= '0;
      byp     <= 1'b0;
      set_tgl <= 1'b0;
      tlr_q   <= 1'b1;
    end else begin
      ir_sr   <= ir_sr_d;
      ir_q    <= ir_d;
      dr_sr   <= dr_d;
      byp     <= byp_d;
      set_tgl <= tgl_d;
      tlr_q   <= (state == TAP_RESET);
    end
  end

  always_comb begin
    oe_d = (state == TAP_SHF_IR) || (state == TAP_SHF_DR);
    if (state == TAP_SHF_IR) begin
      tdo_d = ir_sr[0];
    end else if (sel_irq) begin
      tdo_d = dr_sr[0];
    end else begin
      tdo_d = byp;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

endmodule

// File: rtl/dbgirq_req_reg.sv
`timescale 1ns/1ps
// CPU-domain request flag: set by synchronized toggle edge, cleared by CPU or TAP reset.
module dbgirq_req_reg #(
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl_sync,
  input  logic             tlr_sync,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);

  localparam int WARM_W = SYNC_STAGES + 1;

  logic              flag, flag_d;
  logic              tgl_ref;
  logic [WARM_W-1:0] warm;
  logic              set_evt;
  logic              clr_req;
  wire               unused_hi = ^wdata[REG_W-1:1];

  assign set_evt = (tgl_sync ^ tgl_ref) & warm[WARM_W-1];
  assign clr_req = wr_en & ~wdata[0];

  always_comb begin
    flag_d = flag;
    if (clr_req) begin
      flag_d = 1'b0;
    end
    if (set_evt) begin
      flag_d = 1'b1;
    end
    if (tlr_sync) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      tgl_ref <= 1'b0;
      warm    <= '0;
    end else begin
      flag    <= flag_d;
      tgl_ref <= tgl_sync;
      warm    <= {warm[WARM_W-2:0], 1'b1};
    end
  end

  assign rdata = {{(REG_W-1){1'b0}}, flag};
  assign irq   = flag;

endmodule

// File: rtl/dbgirq_top.sv
`timescale 1ns/1ps
module dbgirq_top
  import dbgirq_pkg::*;
#(
  parameter int              IR_W        = 8,
  parameter logic [IR_W-1:0] IRQ_CMD     = 8'h60,
  parameter logic [IR_W-1:0] BYPASS_CODE = {IR_W{1'b1}},
  parameter logic [IR_W-1:0] IR_CAPT     = 8'h01,
  parameter int              DR_W        = 32,
  parameter int              REG_W       = 16,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  output logic             cpu_irq
);

  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            set_tgl;
  logic            tlr_tck;
  logic            flag_tck;
  logic            rst_cpu_n;
  logic            tgl_sync;
  logic            tlr_sync;

  dbgirq_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (tap_state)
  );

  dbgirq_scan_path #(
    .IR_W        (IR_W),
    .IRQ_CMD     (IRQ_CMD),
    .BYPASS_CODE (BYPASS_CODE),
    .IR_CAPT     (IR_CAPT),
    .DR_W        (DR_W),
    .REG_W       (REG_W)
  ) u_scan (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (tap_state),
    .tdi      (tdi),
    .flag_tck (flag_tck),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe),
    .ir_q     (ir_q),
    .set_tgl  (set_tgl),
    .tlr_q    (tlr_tck)
  );

  dbgirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk (clk), .rst_n (rst_n), .d (1'b1), .q (rst_cpu_n)
  );

  dbgirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
    .clk (clk), .rst_n (rst_cpu_n), .d (set_tgl), .q (tgl_sync)
  );

  dbgirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_tlr_sync (
    .clk (clk), .rst_n (rst_cpu_n), .d (tlr_tck), .q (tlr_sync)
  );

  dbgirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk (tck), .rst_n (trst_n), .d (cpu_irq), .q (flag_tck)
  );

  dbgirq_req_reg #(
    .REG_W       (REG_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_cpu_n),
    .tgl_sync (tgl_sync),
    .tlr_sync (tlr_sync),
    .wr_en    (cpu_wr_en),
    .wdata    (cpu_wdata),
    .rdata    (cpu_rdata),
    .irq      (cpu_irq)
  );

endmodule

// File: rtl/dbgirq_top_chk.sv
`timescale 1ns/1ps
module dbgirq_top_chk
  import dbgirq_pkg::*;
#(
  parameter int              IR_W        = 8,
  parameter logic [IR_W-1:0] BYPASS_CODE = {IR_W{1'b1}},
  parameter int              REG_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tck,
  input logic             trst_n,
  input logic             cpu_irq,
  input logic             cpu_wr_en,
  input logic             cpu_wdata0,
  input logic [REG_W-1:0] cpu_rdata,
  input logic             tgl_sync,
  input logic             tlr_sync,
  input logic             tdo_oe,
  input tap_state_e       tap_state,
  input logic [IR_W-1:0]  ir_q
);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[REG_W-1:1] == '0);

  p_rise_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> ($past(tgl_sync) != $past(tgl_sync, 2)));

  p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_wdata0 && cpu_irq && !tlr_sync) |=> cpu_irq);

  p_fall_needs_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_irq) |-> ($past(cpu_wr_en && !cpu_wdata0) || $past(tlr_sync)));

  p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !(cpu_wr_en && !cpu_wdata0) && !tlr_sync) |=> cpu_irq);

  p_tlr_loads_bypass_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TAP_RESET) |=> (ir_q == BYPASS_CODE));

  p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> ((tap_state == TAP_SHF_DR) || (tap_state == TAP_SHF_IR)));

endmodule

bind dbgirq_top dbgirq_top_chk #(
  .IR_W        (IR_W),
  .BYPASS_CODE (BYPASS_CODE),
  .REG_W       (REG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tck        (tck),
  .trst_n     (trst_n),
  .cpu_irq    (cpu_irq),
  .cpu_wr_en  (cpu_wr_en),
  .cpu_wdata0 (cpu_wdata[0]),
  .cpu_rdata  (cpu_rdata),
  .tgl_sync   (tgl_sync),
  .tlr_sync   (tlr_sync),
  .tdo_oe     (tdo_oe),
  .tap_state  (tap_state),
  .ir_q       (ir_q)
);

// File: tb/dbgirq_top_test.sv
`timescale 1ns/1ps
module dbgirq_top_test;

  logic        clk, rst_n, tck, trst_n, tms, tdi;
  logic        tdo, tdo_oe;
  logic        cpu_wr_en;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        cpu_irq;

  int n_run  = 0;
  int n_fail = 0;
  int glitch = 0;
  int oe_bad = 0;
  logic oe_seen;

  typedef struct packed {
    logic [7:0]  code;
    logic        wr;
    logic [15:0] wd;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'hFF, 1'b0, 16'h0000, 1'b0},
    '{8'h60, 1'b0, 16'h0000, 1'b1},
    '{8'hFF, 1'b1, 16'hFFFF, 1'b1},
    '{8'h61, 1'b1, 16'hFFFE, 1'b0},
    '{8'h20, 1'b0, 16'h0000, 1'b0},
    '{8'h60, 1'b1, 16'h0001, 1'b1},
    '{8'h60, 1'b1, 16'h8000, 1'b0},
    '{8'h06, 1'b0, 16'h0000, 1'b0},
    '{8'h60, 1'b0, 16'h0000, 1'b1},
    '{8'hE0, 1'b1, 16'hAAAA, 1'b0}
  };

  dbgirq_top uut (
    .tck (tck), .trst_n (trst_n), .tms (tms), .tdi (tdi),
    .tdo (tdo), .tdo_oe (tdo_oe),
    .clk (clk), .rst_n (rst_n),
    .cpu_wr_en (cpu_wr_en), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .cpu_irq (cpu_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One TCK period of 8 clk cycles; rising edge lands on a clk falling edge.
  task automatic tck_cycle(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    repeat (4) @(negedge clk);
    o = tdo;
    oe_seen = tdo_oe;
    tck = 1'b1;
    @(negedge clk);
    if (tdo !== o) glitch++;
    repeat (3) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic load_ir(input logic [7:0] code, input logic race, output logic [7:0] cap);
    logic o;
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    for (int i = 0; i < 8; i++) begin
      tck_cycle(i == 7, code[i], o);
      cap[i] = o;
    end
    tck_cycle(1'b1, 1'b0, o);
    if (!race) begin
      tck_cycle(1'b0, 1'b0, o);
    end else begin
      tms = 1'b0;
      tdi = 1'b0;
      repeat (4) @(negedge clk);
      tck = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R2 set not before third clk edge", cpu_irq, 1'b0);
      cpu_wr_en = 1'b1;
      cpu_wdata = 16'h0000;
      @(negedge clk);
      cpu_wr_en = 1'b0;
      chk("R11 set wins over same-edge clear", cpu_irq, 1'b1);
      @(negedge clk);
      tck = 1'b0;
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tck_cycle(i == n - 1, din[i], o);
      dout[i] = o;
      if (oe_seen !== 1'b1) oe_bad++;
    end
    tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
  endtask

  task automatic cpu_write(input logic [15:0] v);
    @(negedge clk);
    cpu_wr_en = 1'b1;
    cpu_wdata = v;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  cap;
    logic [63:0] dout;
    logic        o;
    rst_n = 1'b0; trst_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
    cpu_wr_en = 1'b0; cpu_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; trst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 reset read value", cpu_rdata, 16'h0000);
    chk("R4 reset irq", cpu_irq, 1'b0);
    chk("R10 reset tdo_oe", tdo_oe, 1'b0);
    tck_cycle(1'b0, 1'b0, o);

    // Vector table: IR load, optional CPU write, then expected flag.
    for (int k = 0; k < 10; k++) begin
      load_ir(VECS[k].code, 1'b0, cap);
      chk("R9 IR capture value", cap, 8'h01);
      repeat (8) @(negedge clk);
      if (VECS[k].wr) cpu_write(VECS[k].wd);
      @(negedge clk);
      chk("R2/R3 flag via rdata, R1 upper zero", cpu_rdata, {15'b0, VECS[k].exp});
      chk("R4 irq follows flag", cpu_irq, VECS[k].exp);
    end
    chk("R10 tdo_oe low in idle", tdo_oe, 1'b0);

    // R6: 32-bit path, capture of set flag, length check.
    load_ir(8'h60, 1'b0, cap);
    repeat (8) @(negedge clk);
    scan_dr(33, 64'h1, dout);
    chk("R6 captured image", dout[31:0], 32'h0000_0001);
    chk("R6 path length 32", dout[32], 1'b1);
    chk("R8 flag kept after update-dr", cpu_irq, 1'b1);
    scan_dr(32, 64'hFFFF_FFFF, dout);
    chk("R8 all-ones shift did not write", dout[31:0], 32'h0000_0001);
    cpu_write(16'h0000);
    repeat (4) @(negedge clk);
    scan_dr(32, 64'h0, dout);
    chk("R6 capture after clear", dout[31:0], 32'h0);

    // R7: bypass path.
    load_ir(8'hFF, 1'b0, cap);
    scan_dr(5, 64'b10110, dout);
    chk("R7 bypass one-stage delay", dout[4:0], 5'b01100);
    chk("R10 tdo_oe high while shifting", oe_bad, 0);
    chk("R10 tdo stable at rising edge", glitch, 0);

    // R5: TMS-driven Test-Logic-Reset.
    load_ir(8'h60, 1'b0, cap);
    repeat (8) @(negedge clk);
    chk("R2 set before tlr test", cpu_irq, 1'b1);
    for (int j = 0; j < 5; j++) tck_cycle(1'b1, 1'b0, o);
    repeat (16) @(negedge clk);
    chk("R5 tlr clears flag", cpu_irq, 1'b0);
    tck_cycle(1'b0, 1'b0, o);
    scan_dr(2, 64'b01, dout);
    chk("R5 tlr selects bypass", dout[1:0], 2'b10);

    // R5: trst_n.
    load_ir(8'h60, 1'b0, cap);
    repeat (8) @(negedge clk);
    trst_n = 1'b0;
    repeat (2) @(negedge clk);
    trst_n = 1'b1;
    repeat (16) @(negedge clk);
    chk("R5 trst clears flag", cpu_irq, 1'b0);
    tck_cycle(1'b0, 1'b0, o);

    // R5: system reset, and no set on release.
    load_ir(8'h60, 1'b0, cap);
    repeat (8) @(negedge clk);
    chk("R2 set before rst test", cpu_irq, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R5 rst_n clears flag", cpu_irq, 1'b0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R5 no set on reset release", cpu_irq, 1'b0);

    // R11: set and clear on the same clk edge.
    load_ir(8'h60, 1'b1, cap);
    repeat (8) @(negedge clk);
    chk("R11 flag stays set", cpu_irq, 1'b1);
    cpu_write(16'hFFFE);
    @(negedge clk);
    chk("R3 clear with upper bits set", cpu_rdata, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule